// File: doc/BRIEF.md
# Quad-Channel Converter Serial Write Sequencer

This block sits on a host system clock and turns update requests into the serial traffic a four-channel, 12-bit voltage-output converter expects. A request carries a 2-bit channel number and a 12-bit code on a valid/ready stream. The block builds a 16-bit word from these fields and shifts it out most significant bit first on rising serial-clock edges while chip select is low. It then pulses the load strobe low so the addressed channel takes the new code. It can also issue a converter reset pulse, with the reset-select level driven to the requested value before the pulse starts.

Back-pressure is simple. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Once a request is taken, `req_ready` stays low until the frame has been shifted, the load pulse has ended, and the load-to-clock recovery time has run out. A requester may keep `req_valid` high with the next request. That request is taken as soon as `req_ready` returns. `req_ready` also reads low during any cycle in which `cvt_reset_req` is high, because a reset request takes priority over a write in the same cycle.

Every interface minimum is a parameter in nanoseconds. Each one is turned into a system-clock cycle count by ceiling division at elaboration. The serial clock rests high between frames.

Top module: `dac_quad_seq`

## Requirements
- R1: Each frame is 16 bits, sampled by the converter on rising `dac_sclk` while `dac_cs_n` is low, most significant bit first. Bits 15:14 carry the channel, bits 13:12 are driven 0, and bits 11:0 carry the code.
- R2: `dac_sdi` is stable at least T_DS_NS (25 ns) before every rising serial-clock edge and at least T_DH_NS (20 ns) after it.
- R3: Each serial-clock high phase lasts at least T_CH_NS (30 ns) and each low phase at least T_CL_NS (50 ns).
- R4: `dac_cs_n` falls at least T_CSS_NS (55 ns) before the first rising edge. It rises only while `dac_sclk` is high, and no sooner than T_CSH_NS (15 ns) after the last rising edge.
- R5: `dac_load_n` falls no sooner than T_LD2_NS (15 ns) after the last rising edge, only with chip select high, and stays low at least T_LDW_NS (45 ns).
- R6: No rising serial-clock edge occurs while `dac_load_n` is low. `dac_load_n` is high at least T_LD1_NS (40 ns) before the first rising edge of the next frame.
- R7: A converter reset drives `dac_rstsel` to `cvt_reset_mid` at least T_RSS_NS (25 ns) before `dac_rst_n` falls. It keeps `dac_rstsel` stable while `dac_rst_n` is low, and holds `dac_rst_n` low at least T_RSTW_NS (70 ns).
- R8: `req_ready` falls in the cycle after a handshake. It rises again no sooner than T_LD1_NS after the load strobe rises. Exactly one frame goes out per handshake, even when `req_valid` is held high.
- R9: Whenever `dac_cs_n` is high, `dac_sclk` is high. After reset, `dac_cs_n`, `dac_sclk`, `dac_load_n`, `dac_rst_n` and `req_ready` are all high.
- R10: A `cvt_reset_req` strobe is ignored while the block is busy. When raised together with `req_valid` at idle, it forces `req_ready` low, and its reset pulse completes before that write's chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_chan | input | 2 | Channel number of the request |
| req_code | input | 12 | Code for the channel |
| cvt_reset_req | input | 1 | Strobe requesting a converter reset pulse |
| cvt_reset_mid | input | 1 | Reset-select level to apply (1 = mid-scale) |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sclk | output | 1 | Converter serial clock, idles high |
| dac_sdi | output | 1 | Converter serial data |
| dac_load_n | output | 1 | Converter load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_rstsel | output | 1 | Converter reset-select level |

## Verification
A corrupt bit counter or shift register shows up at the ports on the same frame. It appears as a captured word that does not match the request, or as a load pulse after the wrong number of rising edges. That is visible at the load strobe, within about 200 cycles of the handshake. A wrong phase timer shows up within one serial-clock phase as a pin interval shorter than its nanosecond minimum. The bench measures every interval at the pins and compares it against the spec values.

A state machine that leaves idle wrongly appears as `req_ready` falling without a handshake, a second frame, or a stray reset pulse. The bench looks for these in the cycles after each scenario ends.

// File: rtl/dqs_pkg.sv
package dqs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_LOW, S_HIGH, S_LOAD, S_REC, S_RSET, S_RLOW
  } seq_st_t;

  // ceiling conversion of a nanosecond minimum into clock cycles, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dqs_timer.sv
module dqs_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dqs_shift.sv
module dqs_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (load)   sr_q <= din;
    else if (shift)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/dac_quad_seq.sv
module dac_quad_seq
  import dqs_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned CHAN_W        = 2,
  parameter int unsigned PAD_W         = 2,
  parameter int unsigned CODE_W        = 12,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned T_DH_NS       = 20,
  parameter int unsigned T_CH_NS       = 30,
  parameter int unsigned T_CL_NS       = 50,
  parameter int unsigned T_CSS_NS      = 55,
  parameter int unsigned T_CSH_NS      = 15,
  parameter int unsigned T_LD1_NS      = 40,
  parameter int unsigned T_LD2_NS      = 15,
  parameter int unsigned T_LDW_NS      = 45,
  parameter int unsigned T_RSS_NS      = 25,
  parameter int unsigned T_RSTW_NS     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              cvt_reset_req,
  input  logic              cvt_reset_mid,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_load_n,
  output logic              dac_rst_n,
  output logic              dac_rstsel
);
  localparam int unsigned FRAME_W = CHAN_W + PAD_W + CODE_W;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam int unsigned N_LOW   = umax(ns_to_cyc(T_CL_NS, CLK_PERIOD_NS), ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
  localparam int unsigned N_HIGH  = umax(ns_to_cyc(T_CH_NS, CLK_PERIOD_NS), ns_to_cyc(T_DH_NS, CLK_PERIOD_NS));
  localparam int unsigned N_LAST  = umax(N_HIGH, umax(ns_to_cyc(T_CSH_NS, CLK_PERIOD_NS),
                                                      ns_to_cyc(T_LD2_NS, CLK_PERIOD_NS)));
  localparam int unsigned N_LEAD  = ns_to_cyc(T_CSS_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_LOAD  = ns_to_cyc(T_LDW_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_REC   = ns_to_cyc(T_LD1_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_RSET  = ns_to_cyc(T_RSS_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_RLOW  = ns_to_cyc(T_RSTW_NS, CLK_PERIOD_NS);
  localparam int unsigned N_MAX   = umax(umax(umax(N_LOW, N_LAST), umax(N_LEAD, N_LOAD)),
                                         umax(N_REC, umax(N_RSET, N_RLOW)));
  localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

  seq_st_t          st_q, st_d;
  logic             phase_done;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [IDX_W-1:0] bit_q;
  logic             last_bit;
  logic             take_req;
  logic             take_rst;
  logic             bit_adv;
  int unsigned      dur;

  assign last_bit  = (bit_q == IDX_W'(FRAME_W - 1));
  assign take_rst  = (st_q == S_IDLE) && cvt_reset_req;
  assign req_ready = (st_q == S_IDLE) && !cvt_reset_req;
  assign take_req  = req_ready && req_valid;
  assign bit_adv   = (st_q == S_HIGH) && (st_d == S_LOW);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (take_rst) st_d = S_RSET;
              else if (take_req) st_d = S_LEAD;
      S_LEAD: if (phase_done) st_d = S_LOW;
      S_LOW:  if (phase_done) st_d = S_HIGH;
      S_HIGH: if (phase_done) st_d = last_bit ? S_LOAD : S_LOW;
      S_LOAD: if (phase_done) st_d = S_REC;
      S_REC:  if (phase_done) st_d = S_IDLE;
      S_RSET: if (phase_done) st_d = S_RLOW;
      S_RLOW: if (phase_done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      S_LEAD:  dur = N_LEAD;
      S_LOW:   dur = N_LOW;
      S_HIGH:  dur = last_bit ? N_LAST : N_HIGH;
      S_LOAD:  dur = N_LOAD;
      S_REC:   dur = N_REC;
      S_RSET:  dur = N_RSET;
      S_RLOW:  dur = N_RLOW;
      default: dur = 1;
    endcase
  end

  assign tmr_load = (st_d != st_q);
  assign tmr_val  = CNT_W'(dur - 1);

  dqs_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (phase_done)
  );

  dqs_shift #(.W(FRAME_W)) i_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take_req),
    .din  ({req_chan, {PAD_W{1'b0}}, req_code}),
    .shift(bit_adv),
    .msb  (dac_sdi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      bit_q      <= '0;
      dac_cs_n   <= 1'b1;
      dac_sclk   <= 1'b1;
      dac_load_n <= 1'b1;
      dac_rst_n  <= 1'b1;
      dac_rstsel <= 1'b0;
    end else begin
      st_q       <= st_d;
      if (take_req)     bit_q <= '0;
      else if (bit_adv) bit_q <= bit_q + 1'b1;
      if (take_rst)     dac_rstsel <= cvt_reset_mid;
      dac_cs_n   <= !((st_d == S_LEAD) || (st_d == S_LOW) || (st_d == S_HIGH));
      dac_sclk   <= (st_d != S_LOW);
      dac_load_n <= (st_d != S_LOAD);
      dac_rst_n  <= (st_d != S_RLOW);
    end
  end
endmodule

// File: rtl/dqs_checker.sv
module dqs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_load_n,
  input logic dac_rst_n,
  input logic dac_rstsel
);
  // R9
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> dac_sclk);

  // R6
  load_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load_n |-> dac_sclk);

  // R4
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (dac_sclk && $past(dac_sclk)));

  // R5
  load_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load_n |-> dac_cs_n);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_rst_n |-> $stable(dac_rstsel));
endmodule

bind dac_quad_seq dqs_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dac_cs_n  (dac_cs_n),
  .dac_sclk  (dac_sclk),
  .dac_load_n(dac_load_n),
  .dac_rst_n (dac_rst_n),
  .dac_rstsel(dac_rstsel)
);

// File: tb/test_dac_quad_seq.sv
`timescale 1ns/1ps
module test_dac_quad_seq;
  localparam int PER = 8;
  localparam int TDS = 25, TDH = 20, TCH = 30, TCL = 50, TCSS = 55, TCSH = 15;
  localparam int TLD1 = 40, TLD2 = 15, TLDW = 45, TRSS = 25, TRSTW = 70;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_chan = 0;
  logic [11:0] req_code = 0;
  logic cvt_reset_req = 0;
  logic cvt_reset_mid = 0;
  logic dac_cs_n, dac_sclk, dac_sdi, dac_load_n, dac_rst_n, dac_rstsel;

  always #4 clk = ~clk;

  dac_quad_seq i_dac_quad_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .cvt_reset_req(cvt_reset_req),
    .cvt_reset_mid(cvt_reset_mid), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk),
    .dac_sdi(dac_sdi), .dac_load_n(dac_load_n), .dac_rst_n(dac_rst_n),
    .dac_rstsel(dac_rstsel)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, mon_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor: times every interval in ns against the spec minimums
  logic p_sclk = 1, p_cs = 1, p_ld = 1, p_rst = 1, p_sdi = 0, p_sel = 0, p_rdy = 1;
  int lo_len = 0, hi_len = 0, since_rise = 1000, sdi_age = 1000, cs_age = 0;
  int since_ldr = 1000, sel_age = 1000, ld_len = 0, rlow_len = 0, cyc = 0;
  int nbits = 0, frame_cnt = 0, rst_cnt = 0, rst_rise_cyc = 0, cs_fall_cyc = 0;
  bit ld_pend = 0;
  logic [15:0] cap = 0, last_frame = 0, prev_frame = 0;
  logic exp_sel = 0;

  always @(negedge clk) if (mon_en) begin
    cyc++; since_rise++; sdi_age++; cs_age++; since_ldr++; sel_age++;
    lo_len++; hi_len++; ld_len++; rlow_len++;
    if (dac_sdi !== p_sdi) begin
      if (!p_cs) chk(since_rise * PER >= TDH, "R2 hold", since_rise * PER, TDH);
      sdi_age = 0;
    end
    if (!p_sclk && dac_sclk) begin
      chk(lo_len * PER >= TCL, "R3 low", lo_len * PER, TCL);
      chk(sdi_age * PER >= TDS, "R2 setup", sdi_age * PER, TDS);
      chk(dac_load_n == 1'b1, "R6 edge in load", dac_load_n, 1);
      if (nbits == 0) begin
        chk(cs_age * PER >= TCSS, "R4 lead", cs_age * PER, TCSS);
        chk(since_ldr * PER >= TLD1, "R6 load recovery", since_ldr * PER, TLD1);
      end
      cap = {cap[14:0], dac_sdi};
      nbits++;
      since_rise = 0; hi_len = 0;
    end
    if (p_sclk && !dac_sclk) begin
      chk(hi_len * PER >= TCH, "R3 high", hi_len * PER, TCH);
      lo_len = 0;
    end
    if (p_cs && !dac_cs_n) begin cs_age = 0; nbits = 0; cs_fall_cyc = cyc; end
    if (!p_cs && dac_cs_n) begin
      chk(p_sclk && dac_sclk, "R4 cs rise with clock high", dac_sclk, 1);
      chk(since_rise * PER >= TCSH, "R4 cs hold", since_rise * PER, TCSH);
    end
    if (dac_cs_n) chk(dac_sclk == 1'b1, "R9 idle clock", dac_sclk, 1);
    if (p_ld && !dac_load_n) begin
      chk(since_rise * PER >= TLD2, "R5 load after edge", since_rise * PER, TLD2);
      chk(nbits == 16, "R1 bit count", nbits, 16);
      prev_frame = last_frame; last_frame = cap; frame_cnt++; ld_len = 0;
    end
    if (!p_ld && dac_load_n) begin
      chk(ld_len * PER >= TLDW, "R5 load width", ld_len * PER, TLDW);
      since_ldr = 0; ld_pend = 1;
    end
    if (!p_rdy && req_ready && ld_pend) begin
      chk(since_ldr * PER >= TLD1, "R8 ready return", since_ldr * PER, TLD1);
      ld_pend = 0;
    end
    if (dac_rstsel !== p_sel) sel_age = 0;
    if (p_rst && !dac_rst_n) begin
      chk(sel_age * PER >= TRSS, "R7 select setup", sel_age * PER, TRSS);
      chk(dac_rstsel == exp_sel, "R7 select level", dac_rstsel, exp_sel);
      rlow_len = 0;
    end
    if (!p_rst && dac_rst_n) begin
      chk(rlow_len * PER >= TRSTW, "R7 reset width", rlow_len * PER, TRSTW);
      rst_cnt++; rst_rise_cyc = cyc;
    end
    p_sclk = dac_sclk; p_cs = dac_cs_n; p_ld = dac_load_n; p_rst = dac_rst_n;
    p_sdi = dac_sdi; p_sel = dac_rstsel; p_rdy = req_ready;
  end

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (!req_ready);
  endtask

  task automatic t_reset_state();
    @(negedge clk); #1;
    chk(dac_cs_n && dac_sclk && dac_load_n && dac_rst_n, "R9 reset pins",
        {dac_cs_n, dac_sclk, dac_load_n, dac_rst_n}, 4'hf);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
  endtask

  task automatic t_write(input logic [1:0] ch, input logic [11:0] code);
    logic [15:0] exp = {ch, 2'b00, code};
    int f0 = frame_cnt;
    @(negedge clk); req_valid = 1; req_chan = ch; req_code = code; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0; #1;
    chk(req_ready == 1'b0, "R8 ready low after take", req_ready, 0);
    wait_idle();
    chk(frame_cnt == f0 + 1, "R8 one frame", frame_cnt - f0, 1);
    chk(last_frame == exp, "R1 frame", last_frame, exp);
  endtask

  task automatic t_back_to_back();
    int f0 = frame_cnt;
    @(negedge clk); req_valid = 1; req_chan = 2'd2; req_code = 12'h5a5; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_chan = 2'd1; req_code = 12'h0f3; #1;
    chk(req_ready == 1'b0, "R8 held valid stalls", req_ready, 0);
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(frame_cnt == f0 + 2, "R8 two frames", frame_cnt - f0, 2);
    chk(prev_frame == 16'h85a5, "R1 first of pair", prev_frame, 16'h85a5);
    chk(last_frame == 16'h40f3, "R1 second of pair", last_frame, 16'h40f3);
  endtask

  task automatic t_cvt_reset(input logic mid);
    int r0 = rst_cnt;
    @(negedge clk); cvt_reset_req = 1; cvt_reset_mid = mid; exp_sel = mid; #1;
    chk(req_ready == 1'b0, "R10 ready low on reset strobe", req_ready, 0);
    @(negedge clk); cvt_reset_req = 0;
    wait_idle();
    chk(rst_cnt == r0 + 1, "R7 one reset pulse", rst_cnt - r0, 1);
    chk(dac_rstsel == mid, "R7 select kept", dac_rstsel, mid);
  endtask

  task automatic t_reset_while_busy();
    int r0 = rst_cnt;
    logic keep = dac_rstsel;
    @(negedge clk); req_valid = 1; req_chan = 2'd3; req_code = 12'h001; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    repeat (5) @(negedge clk);
    cvt_reset_req = 1; cvt_reset_mid = ~keep;
    @(negedge clk); cvt_reset_req = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rst_cnt == r0, "R10 busy strobe ignored", rst_cnt - r0, 0);
    chk(dac_rstsel == keep, "R10 select untouched", dac_rstsel, keep);
    chk(last_frame == 16'hc001, "R1 frame during ignored strobe", last_frame, 16'hc001);
  endtask

  task automatic t_reset_with_write();
    int r0 = rst_cnt;
    @(negedge clk); req_valid = 1; req_chan = 2'd0; req_code = 12'h800;
    cvt_reset_req = 1; cvt_reset_mid = 1; exp_sel = 1; #1;
    chk(req_ready == 1'b0, "R10 reset wins", req_ready, 0);
    @(negedge clk); cvt_reset_req = 0; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    wait_idle();
    chk(rst_cnt == r0 + 1, "R10 reset done", rst_cnt - r0, 1);
    chk(rst_rise_cyc < cs_fall_cyc, "R10 reset before frame", rst_rise_cyc, cs_fall_cyc);
    chk(last_frame == 16'h0800, "R1 frame after reset", last_frame, 16'h0800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; mon_en = 1;
    t_reset_state();
    t_write(2'd0, 12'h000);
    t_write(2'd3, 12'hfff);
    t_write(2'd1, 12'ha5a);
    t_write(2'd2, 12'h5a5);
    t_back_to_back();
    t_cvt_reset(1'b1);
    t_cvt_reset(1'b0);
    t_reset_while_busy();
    t_reset_with_write();
    repeat (10) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule